// File: doc/BRIEF.md
# Pulse Accumulator Event Counter

This block is an 8-bit accumulator fed by one external pulse line. It has two modes. In edge mode the register goes up by one on every active transition of the line. In gated mode it goes up by one on every tick of a free-running divide-by-64 prescaler, but only while the line sits at the chosen level. A single polarity input chooses which edge or which level counts.

Software reads the accumulator and writes it at any time through a simple bus port. Reset clears the synchroniser, the prescaler and the overflow strobe. The count value stays as it was, so reset never clears or loads it. When the count rolls over from its top value back to zero, the block emits a one-clock overflow strobe.

Top module: `pulse_acc_counter`

## Requirements
- R1: A bus write (`bus_wr`=1) loads `bus_wdata` into the count. The new value shows on `bus_rdata` after the next rising clock edge.
- R2: When a write and an increment fall in the same cycle, the written value is stored and the increment is lost.
- R3: With `mode_gated`=0, each active edge of `pulse_in` adds one to the count. With `pol_sel`=0 the active edge is rising; with `pol_sel`=1 it is falling. The line passes through a two-flop synchroniser, so an edge is counted within four clocks.
- R4: With `mode_gated`=1, each `presc_tick` cycle adds one to the count while the synchronised `pulse_in` is at the active level. With `pol_sel`=0 the active level is high; with `pol_sel`=1 it is low.
- R5: With `mode_gated`=1 and `pulse_in` held at the inactive level, the count does not change. Edges have no effect in this mode.
- R6: `presc_tick` is a single-cycle enable from a free-running prescaler. It is high in exactly one clock out of every 64 and does not depend on the mode.
- R7: Asserting `rst_n` low leaves the count value unchanged.
- R8: An increment from 0xFF gives 0x00. `ovf_pulse` is high for exactly the one clock in which 0x00 first appears.
- R9: `bus_rdata` shows the count register, which changes only at a clock edge. Without a write it either holds or moves up by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (count kept) |
| pulse_in | input | 1 | External pulse line, asynchronous |
| mode_gated | input | 1 | 0 = edge counting, 1 = gated accumulation |
| pol_sel | input | 1 | 0 = rising edge / high level, 1 = falling edge / low level |
| bus_wr | input | 1 | Write strobe for the count |
| bus_wdata | input | 8 | Value to load |
| bus_rdata | output | 8 | Current count |
| presc_tick | output | 1 | Prescaler enable, one clock in 64 |
| ovf_pulse | output | 1 | One-clock strobe on wrap to zero |

## Verification
The properties assume that the count holds a defined value before any increment can occur. They also assume that the pulse line and the selects settle well away from clock edges. The stimulus therefore writes the count right after reset, while `pulse_in` is low and edge mode is selected. It keeps each pulse level for four clocks, so every transition clears the synchroniser before the next one arrives. The gated sweeps let the level settle before taking a snapshot. They then count the `presc_tick` cycles actually seen at the port, so the expected total does not depend on the prescaler's phase.

// File: rtl/pulse_acc_counter.sv
module pulse_acc_counter #(
  parameter int CNT_W       = 8,
  parameter int PRESC_DIV   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             mode_gated,
  input  logic             pol_sel,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             presc_tick,
  output logic             ovf_pulse
);
  localparam int PW = $clog2(PRESC_DIV);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [PW-1:0]          presc_q;
  logic [CNT_W-1:0]       count_q;
  logic                   ovf_q;

  wire line     = sync_q[SYNC_STAGES-1];
  wire edge_hit = pol_sel ? (prev_q & ~line) : (~prev_q & line);
  wire lvl_hit  = line ^ pol_sel;
  wire inc      = mode_gated ? (presc_tick & lvl_hit) : edge_hit;

  assign presc_tick = (presc_q == PW'(PRESC_DIV - 1));
  assign bus_rdata  = count_q;
  assign ovf_pulse  = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      presc_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pulse_in};
      prev_q  <= line;
      presc_q <= presc_tick ? '0 : presc_q + 1'b1;
      ovf_q   <= inc & ~bus_wr & (count_q == '1);
    end
  end

  // no reset: the count survives it
  always_ff @(posedge clk) begin
    if (bus_wr)   count_q <= bus_wdata;
    else if (inc) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/pulse_acc_counter_chk.sv
module pulse_acc_counter_chk #(
  parameter int CNT_W     = 8,
  parameter int PRESC_DIV = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_gated,
  input logic             bus_wr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] bus_rdata,
  input logic             presc_tick,
  input logic             ovf_pulse
);
  logic [15:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= presc_tick ? 16'd0 : gap_q + 16'd1;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> bus_rdata == $past(bus_wdata)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (bus_rdata == $past(bus_rdata) ||
                 bus_rdata == CNT_W'($past(bus_rdata) + 1'b1))); // R9
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_gated && !presc_tick && !bus_wr) |=> $stable(bus_rdata)); // R4
  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    presc_tick |-> gap_q == 16'(PRESC_DIV - 1)); // R6
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    presc_tick |=> !presc_tick); // R6
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (bus_rdata == '0 && $past(bus_rdata) == '1)); // R8
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R8
endmodule

bind pulse_acc_counter pulse_acc_counter_chk #(
  .CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_gated(mode_gated), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
  .ovf_pulse(ovf_pulse)
);

// File: tb/pulse_acc_counter_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0, mode_gated = 1'b0, pol_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic presc_tick, ovf_pulse;
  int n_chk = 0, n_bad = 0, ovf_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_acc_counter dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .mode_gated(mode_gated),
    .pol_sel(pol_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .presc_tick(presc_tick), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (ovf_pulse) ovf_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic pulse_once();
    pulse_in = 1'b1; repeat (4) @(negedge clk);
    pulse_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk(ovf_pulse == 1'b0, "R8 reset ovf", ovf_pulse, 0);
    chk(presc_tick == 1'b0, "R6 reset tick", presc_tick, 0);

    // R1 write loads
    for (int v = 0; v < 256; v += 17) begin
      wr(8'(v));
      chk(bus_rdata == 8'(v), "R1", bus_rdata, v);
    end

    // R7 reset retention
    wr(8'hA5);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rdata == 8'hA5, "R7", bus_rdata, 8'hA5);

    // R3 edge counting sweep, both polarities
    for (int p = 0; p < 2; p++) begin
      pol_sel = p[0];
      repeat (4) @(negedge clk);
      for (int n = 0; n <= 12; n++) begin
        logic [7:0] snap;
        snap = bus_rdata;
        for (int k = 0; k < n; k++) pulse_once();
        chk(bus_rdata == 8'(snap + n), "R3", bus_rdata, 8'(snap + n));
      end
    end

    // R3 a long high level gives one count only
    pol_sel = 1'b0;
    begin
      logic [7:0] snap;
      snap = bus_rdata;
      pulse_in = 1'b1; repeat (40) @(negedge clk);
      pulse_in = 1'b0; repeat (4) @(negedge clk);
      chk(bus_rdata == 8'(snap + 1), "R3 level", bus_rdata, 8'(snap + 1));
    end

    // R6 prescaler spacing
    while (!presc_tick) @(negedge clk);
    for (int t = 0; t < 5; t++) begin
      int gap;
      gap = 0;
      do begin @(negedge clk); gap++; end while (!presc_tick);
      chk(gap == 64, "R6", gap, 64);
    end

    // R4 / R5 gated sweep over polarity and level
    mode_gated = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 2; l++) begin
        logic [7:0] snap;
        int ticks;
        bit act;
        pol_sel = p[0]; pulse_in = l[0];
        repeat (4) @(negedge clk);
        snap = bus_rdata; ticks = 0;
        act = (l[0] ^ p[0]);
        for (int c = 0; c < 300; c++) begin
          if (presc_tick) ticks++;
          @(negedge clk);
        end
        if (act) chk(bus_rdata == 8'(snap + ticks), "R4", bus_rdata, 8'(snap + ticks));
        else     chk(bus_rdata == snap, "R5", bus_rdata, snap);
      end
    end

    // R5 edges ignored in gated mode at the inactive level
    pol_sel = 1'b0; pulse_in = 1'b0;
    repeat (4) @(negedge clk);
    while (presc_tick) @(negedge clk);
    begin
      logic [7:0] snap;
      snap = bus_rdata;
      pulse_in = 1'b1; @(negedge clk); pulse_in = 1'b0;
      repeat (40) @(negedge clk);
      chk(bus_rdata == snap, "R5 edge", bus_rdata, snap);
    end

    // R2 write wins over a coinciding tick
    pol_sel = 1'b0; pulse_in = 1'b1;
    repeat (4) @(negedge clk);
    while (!presc_tick) @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h3C;
    @(negedge clk); bus_wr = 1'b0;
    chk(bus_rdata == 8'h3C, "R2", bus_rdata, 8'h3C);
    pulse_in = 1'b0; mode_gated = 1'b0;
    repeat (4) @(negedge clk);

    // R8 wrap and overflow strobe
    wr(8'hFE);
    ovf_seen = 0;
    pulse_once();
    chk(bus_rdata == 8'hFF, "R8 pre", bus_rdata, 8'hFF);
    chk(ovf_seen == 0, "R8 no strobe", ovf_seen, 0);
    pulse_once();
    chk(bus_rdata == 8'h00, "R8 wrap", bus_rdata, 0);
    chk(ovf_seen == 1, "R8 strobe", ovf_seen, 1);

    // R9 read stable between edges
    begin
      logic [7:0] a;
      @(negedge clk); a = bus_rdata; #1;
      chk(bus_rdata == a, "R9", bus_rdata, a);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule